// File: doc/BRIEF.md
# Sign-Magnitude Add/Subtract Unit

This block adds or subtracts two signed numbers kept in sign-magnitude form: a 4-bit magnitude with a separate sign bit. The first operand lives in an accumulator (magnitude register plus sign register). The second operand lives in a holding register. Both are loaded from one 5-bit operand word. In that word bit 4 is the sign (1 = negative) and bits 3..0 are the magnitude.

A one-cycle start request runs one operation. The unit compares the two signs with the requested operation and picks one of two paths. One path adds the magnitudes and reports the carry as overflow. The other path subtracts them through a single XOR-fed ripple adder, computing A + ~B + 1. In that path the carry out decides whether the raw sum is kept or replaced by its two's complement, with the accumulator sign inverted. The result goes back into the accumulator magnitude and sign, and the overflow bit goes into its own flag register. A registered done pulse follows each operation. The accumulator is the result, so operations can be chained by starting again without reloading.

Top module: `smag_addsub`

## Requirements
- R1: While `rst` is high at a rising clock edge, the accumulator magnitude, accumulator sign, overflow flag and `done` are all cleared to 0.
- R2: With `start` low, `loadA` high copies `opWord[3:0]` into the accumulator magnitude and `opWord[4]` into the accumulator sign, visible on `resMag`/`resSign` after that edge. `loadB` likewise stores the second operand. Loads never change `resOvf`.
- R3: `subMode` = 0 requests add and 1 requests subtract. The magnitudes are added when `subMode` XOR accumulator sign XOR B sign is 0, and subtracted otherwise.
- R4: On the magnitude-add path, `resMag` becomes the low 4 bits of A + B. `resOvf` becomes the carry out (1 when A + B > 15). The accumulator sign keeps its value, even for a zero result.
- R5: On the magnitude-subtract path, `resOvf` is cleared. When A >= B (carry out 1), `resMag` becomes A − B and the sign is kept, except that a zero result forces the sign to 0.
- R6: On the magnitude-subtract path with A < B (carry out 0), `resMag` becomes B − A (the two's complement of the raw sum) and the accumulator sign is inverted.
- R7: `done` is high for exactly the one cycle after each edge at which `start` was sampled high, and low after any edge with `start` low.
- R8: When `start` is high, `loadA` and `loadB` in the same cycle are ignored: the operation uses the stored operands, and B stays unchanged for later operations.
- R9: A start in the cycle where the previous `done` is high is accepted as a new operation on the updated accumulator. With `start`, `loadA` and `rst` low, the accumulator and overflow flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| loadA | input | 1 | Load operand word into accumulator |
| loadB | input | 1 | Load operand word into B register |
| opWord | input | 5 | Operand: bit 4 sign, bits 3..0 magnitude |
| start | input | 1 | One-cycle operation request |
| subMode | input | 1 | 0 = add, 1 = subtract |
| resMag | output | 4 | Accumulator magnitude (result) |
| resSign | output | 1 | Accumulator sign (1 = negative) |
| resOvf | output | 1 | Overflow flag from last operation |
| done | output | 1 | One-cycle pulse after an operation |

## Verification
The bench builds the unit at its default 4-bit magnitude width. At that width every combination of the two magnitudes, both signs and the mode can be swept: 2048 operations. That sweep reaches every path: carry and no carry on the add path, equal magnitudes giving a forced positive zero, A < B giving complement-and-invert, and negative-zero operands. Directed sequences cover loads colliding with start, held start chaining on the accumulator, and the done pulse shape.

// File: rtl/smag_pkg.sv
package smag_pkg;
  localparam int SMAG_W = 4;

  typedef struct packed {
    logic ldA;
    logic ldB;
    logic exec;
  } smag_ctrl_t;
endpackage

// File: rtl/smag_ctrl.sv
module smag_ctrl
  import smag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loadA,
  input  logic       loadB,
  input  logic       start,
  output smag_ctrl_t ctl,
  output logic       done
);
  // start wins over loads in the same cycle
  always_comb begin
    ctl.exec = start;
    ctl.ldA  = loadA & ~start;
    ctl.ldB  = loadB & ~start;
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= start;
  end
endmodule

// File: rtl/smag_dp.sv
module smag_dp
  import smag_pkg::*;
#(
  parameter int W = SMAG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  smag_ctrl_t   ctl,
  input  logic [W:0]   opWord,
  input  logic         subMode,
  output logic [W-1:0] aMag,
  output logic         aSign,
  output logic         ovf
);
  logic [W-1:0] bMag;
  logic         bSign;
  logic         effSub;
  logic [W-1:0] bX;
  logic [W-1:0] sum;
  logic [W:0]   carry;
  logic [W-1:0] negSum;
  logic         sumZero;
  logic [W-1:0] nextMag;
  logic         nextSign;
  logic         nextOvf;
  logic [W-1:0] nextBMag;
  logic         nextBSign;

  assign effSub   = subMode ^ aSign ^ bSign;
  assign carry[0] = effSub;

  // XOR-fed ripple adder: effSub=1 gives A + ~B + 1
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bX[i]      = bMag[i] ^ effSub;
    assign sum[i]     = aMag[i] ^ bX[i] ^ carry[i];
    assign carry[i+1] = (aMag[i] & bX[i]) | (aMag[i] & carry[i]) | (bX[i] & carry[i]);
  end

  assign negSum  = ~sum + {{(W-1){1'b0}}, 1'b1};
  assign sumZero = (sum == '0);

  always_comb begin
    nextMag   = aMag;
    nextSign  = aSign;
    nextOvf   = ovf;
    nextBMag  = bMag;
    nextBSign = bSign;
    if (ctl.ldA) begin
      nextMag  = opWord[W-1:0];
      nextSign = opWord[W];
    end
    if (ctl.ldB) begin
      nextBMag  = opWord[W-1:0];
      nextBSign = opWord[W];
    end
    if (ctl.exec) begin
      if (!effSub) begin
        nextMag = sum;
        nextOvf = carry[W];
      end else begin
        nextOvf = 1'b0;
        if (carry[W]) begin
          nextMag = sum;
          if (sumZero) nextSign = 1'b0;
        end else begin
          nextMag  = negSum;
          nextSign = ~aSign;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aMag  <= '0;
      aSign <= 1'b0;
      ovf   <= 1'b0;
      bMag  <= '0;
      bSign <= 1'b0;
    end else begin
      aMag  <= nextMag;
      aSign <= nextSign;
      ovf   <= nextOvf;
      bMag  <= nextBMag;
      bSign <= nextBSign;
    end
  end
endmodule

// File: rtl/smag_addsub.sv
module smag_addsub
  import smag_pkg::*;
#(
  parameter int W = SMAG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loadA,
  input  logic         loadB,
  input  logic [W:0]   opWord,
  input  logic         start,
  input  logic         subMode,
  output logic [W-1:0] resMag,
  output logic         resSign,
  output logic         resOvf,
  output logic         done
);
  smag_ctrl_t ctl;

  smag_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .loadA (loadA),
    .loadB (loadB),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  smag_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .opWord  (opWord),
    .subMode (subMode),
    .aMag    (resMag),
    .aSign   (resSign),
    .ovf     (resOvf)
  );
endmodule

// File: rtl/smag_addsub_chk.sv
module smag_addsub_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         loadA,
  input logic         loadB,
  input logic [W:0]   opWord,
  input logic         start,
  input logic         subMode,
  input logic [W-1:0] resMag,
  input logic         resSign,
  input logic         resOvf,
  input logic         done
);
  // observer copy of the B sign as seen at the ports
  logic shadowBs;
  always_ff @(posedge clk) begin
    if (rst) shadowBs <= 1'b0;
    else if (loadB && !start) shadowBs <= opWord[W];
  end

  logic effSub;
  assign effSub = subMode ^ resSign ^ shadowBs;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (resMag == '0 && !resSign && !resOvf && !done));

  assert_load_a_R2: assert property (@(posedge clk) disable iff (rst)
    (loadA && !start) |=> (resMag == $past(opWord[W-1:0]) && resSign == $past(opWord[W])));

  assert_add_keeps_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !effSub) |=> (resSign == $past(resSign)));

  assert_sub_no_ovf_R5: assert property (@(posedge clk) disable iff (rst)
    (start && effSub) |=> !resOvf);

  assert_sub_no_neg_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (start && effSub) |=> !(resMag == '0 && resSign));

  assert_done_high_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  assert_done_low_R7: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!start && !loadA) |=> ($stable(resMag) && $stable(resSign)));

  assert_ovf_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(resOvf));
endmodule

bind smag_addsub smag_addsub_chk #(.W(W)) u_chk (.*);

// File: tb/smag_addsub_tb.sv
`timescale 1ns/1ps
module smag_addsub_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadA = 1'b0;
  logic       loadB = 1'b0;
  logic [4:0] opWord = '0;
  logic       start = 1'b0;
  logic       subMode = 1'b0;
  logic [3:0] resMag;
  logic       resSign;
  logic       resOvf;
  logic       done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  smag_addsub u_dut (
    .clk(clk), .rst(rst), .loadA(loadA), .loadB(loadB), .opWord(opWord),
    .start(start), .subMode(subMode), .resMag(resMag), .resSign(resSign),
    .resOvf(resOvf), .done(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected {ovf, sign, mag} and path tag from the requirements
  task automatic model(input int a, input int as, input int b, input int bs, input int m,
                       output int eMag, output int eSign, output int eOvf, output string tag);
    int diff;
    if ((m ^ as ^ bs) == 0) begin
      eMag = (a + b) % 16; eOvf = (a + b > 15) ? 1 : 0; eSign = as; tag = "R3 R4";
    end else begin
      diff = a - b; eOvf = 0;
      if (diff >= 0) begin
        eMag = diff; eSign = (diff == 0) ? 0 : as; tag = "R3 R5";
      end else begin
        eMag = -diff; eSign = 1 - as; tag = "R3 R6";
      end
    end
  endtask

  task automatic runOp(input logic [4:0] aw, input logic [4:0] bw, input logic m);
    @(negedge clk); opWord = aw; loadA = 1'b1;
    @(negedge clk); loadA = 1'b0; loadB = 1'b1; opWord = bw;
    @(negedge clk); loadB = 1'b0; start = 1'b1; subMode = m;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int eMag, eSign, eOvf;
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 mag", resMag, 0);
    check("R1 sign", resSign, 0);
    check("R1 ovf", resOvf, 0);
    check("R1 done", done, 0);

    // R2 load accumulator: negative ten
    @(negedge clk); opWord = 5'b1_1010; loadA = 1'b1;
    @(negedge clk); loadA = 1'b0;
    check("R2 mag", resMag, 10);
    check("R2 sign", resSign, 1);
    check("R2 ovf", resOvf, 0);

    // exhaustive sweep
    for (int m = 0; m < 2; m++)
      for (int as = 0; as < 2; as++)
        for (int bs = 0; bs < 2; bs++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
              runOp({as[0], a[3:0]}, {bs[0], b[3:0]}, m[0]);
              model(a, as, b, bs, m, eMag, eSign, eOvf, tag);
              check({tag, " mag"}, resMag, eMag);
              check({tag, " sign"}, resSign, eSign);
              check({tag, " ovf"}, resOvf, eOvf);
              check("R7 done pulse", done, 1);
              if (b == 15) begin
                @(negedge clk);
                check("R7 done low", done, 0);
                check("R9 hold mag", resMag, eMag);
              end
            end

    // R8: loads colliding with start are ignored
    runOp(5'b0_0011, 5'b0_0101, 1'b0);
    check("R8 setup", resMag, 8);
    @(negedge clk); opWord = 5'b1_1111; loadA = 1'b1; loadB = 1'b1; start = 1'b1; subMode = 1'b0;
    @(negedge clk); loadA = 1'b0; loadB = 1'b0; start = 1'b0;
    check("R8 mag", resMag, 13);
    check("R8 sign", resSign, 0);
    @(negedge clk); start = 1'b1; subMode = 1'b1;
    @(negedge clk);
    check("R8 B kept", resMag, 8);
    check("R9 done first", done, 1);
    // R9: start held while done high -> chained operation
    @(negedge clk); start = 1'b0;
    check("R9 chained mag", resMag, 3);
    check("R9 chained sign", resSign, 0);
    check("R9 done second", done, 1);
    @(negedge clk);
    check("R7 done drop", done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule